// File: doc/BRIEF.md
# Periodic and One-Shot Comparator Bank

This block holds a bank of timer comparators that watch a free-running main counter supplied from outside. Each timer stores a compare value and issues a single-cycle `fire` pulse when the counter moves onto or past that value. A timer runs in one of two modes. In one-shot mode it fires once when the counter reaches the programmed value. In periodic mode it also keeps a period register and, after each match, moves its compare point forward by whole periods until that point lies ahead of the counter again.

Software reaches each timer through a simple write port and a combinational read port. Two registers are visible per timer: a configuration word and the comparator. In periodic mode a comparator write always loads the period. It moves the live compare point only when a one-shot "load value" bit has been armed in the configuration, and that bit clears itself after any comparator write. Interrupt delivery and the counter itself live outside this block.

Top module: `cmp_timer_bank`

## Requirements
- R1: After reset every timer's comparator reads 0xFFFFFFFF, its configuration word reads 0x2, and `fire` is low.
- R2: A timer matches when the counter value presented in a cycle has moved, compared with the previous cycle, so that the compare value lies in the half-open span (previous, current], taken modulo 2^32. Its `fire` bit is then high for exactly the following clock cycle.
- R3: In one-shot mode (configuration bit 0 = 0) a comparator value that is already behind the counter causes no match until the counter wraps through zero and reaches it.
- R4: In periodic mode (configuration bit 0 = 1) a comparator write (register select 1) always loads the period. It loads the compare value only when configuration bit 2 (load value) is 1, and otherwise leaves the compare value unchanged.
- R5: Configuration bit 2 reads 0 after any comparator write to that timer, in either mode.
- R6: After a periodic match with a nonzero period, the compare value becomes the first value of the form old + k·period (k ≥ 1) that lies ahead of the counter. Matches are suppressed while it steps forward.
- R7: Writing configuration bit 0 to 0 clears the period to zero. A periodic timer whose period is zero keeps its compare value after a match.
- R8: Configuration bit 1 (periodic capable) always reads 1 and bit 3 (32-bit mode) always reads 0. Writes to these bits have no effect, and all bits above bit 3 read 0.
- R9: A comparator read returns the compare value, never the period.
- R10: No match is reported while `count_en` is low, nor in the first cycle it is high again.
- R11: When a comparator write and a match occur in the same cycle, `fire` still pulses for the old compare value. A value that the write loads takes precedence over the periodic step; when the write does not load a value, the step uses the period held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| count_in | input | 32 | Main counter value |
| count_en | input | 1 | Global counting enable; matches only while high |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Timer addressed by the write |
| wr_reg | input | 1 | Write register select: 0 configuration, 1 comparator |
| wr_data | input | 32 | Write data |
| rd_idx | input | 2 | Timer addressed by the read |
| rd_reg | input | 1 | Read register select: 0 configuration, 1 comparator |
| rd_data | output | 32 | Read data, combinational |
| fire | output | 3 | One-cycle match pulse per timer |

## Verification
A comparator write and a counter match can land in the same clock edge, and the two must be resolved together. The bench provokes this by presenting the counter value that equals the live compare point in the same cycle as the write strobe. It does this once for a one-shot timer with a new value, and once for a periodic timer whose write changes only the period. It judges the outcome by the `fire` pulse in the following cycle and by the comparator read-back: the new value in the first case, and in the second case a step made with the old period followed by a later step made with the new one.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  typedef enum logic {
    REG_CFG = 1'b0,
    REG_CMP = 1'b1
  } reg_sel_e;

  // configuration word bit positions
  localparam int unsigned CFG_PER_BIT  = 0;
  localparam int unsigned CFG_CAP_BIT  = 1;
  localparam int unsigned CFG_VSET_BIT = 2;
  localparam int unsigned CFG_WIDE_BIT = 3;
endpackage

// File: rtl/tcb_cfg.sv
module tcb_cfg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_wr,
  input  logic         cmp_wr,
  input  logic         per_d,
  input  logic         vset_d,
  output logic         per_en,
  output logic         val_set,
  output logic         per_clr,
  output logic [W-1:0] cfg_rd
);
  import tcb_pkg::*;

  logic per_q, per_n;
  logic vs_q, vs_n;
  logic upd;

  always_comb begin
    per_n = per_q;
    vs_n  = vs_q;
    if (cfg_wr) begin
      per_n = per_d;
      vs_n  = vset_d;
    end else if (cmp_wr) begin
      vs_n = 1'b0;
    end
  end

  assign upd     = cfg_wr | cmp_wr;
  assign per_clr = cfg_wr & ~per_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= 1'b0;
      vs_q  <= 1'b0;
    end else if (upd) begin
      per_q <= per_n;
      vs_q  <= vs_n;
    end
  end

  always_comb begin
    cfg_rd               = '0;
    cfg_rd[CFG_PER_BIT]  = per_q;
    cfg_rd[CFG_CAP_BIT]  = 1'b1;
    cfg_rd[CFG_VSET_BIT] = vs_q;
    cfg_rd[CFG_WIDE_BIT] = 1'b0;
  end

  assign per_en  = per_q;
  assign val_set = vs_q;

  // R5
  vset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !vs_q);
endmodule

// File: rtl/tcb_slot.sv
module tcb_slot #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count_in,
  input  logic         count_en,
  input  logic         cmp_wr,
  input  logic [W-1:0] wdata,
  input  logic         per_en,
  input  logic         val_set,
  input  logic         per_clr,
  output logic [W-1:0] cmp_val,
  output logic         fire
);
  logic [W-1:0] cmp_q, cmp_n;
  logic [W-1:0] rate_q, rate_n;
  logic [W-1:0] prev_q;
  logic         en_q;
  logic         busy_q, busy_n;
  logic         fire_q;

  logic [W-1:0] delta, off, lead;
  logic         hit, ahead, load_cmp, rate_upd;

  // crossing detection: compare point inside (prev, now]
  assign delta = count_in - prev_q;
  assign off   = cmp_q - prev_q;
  assign hit   = count_en & en_q & ~busy_q & (off != '0) & (off <= delta);

  // compare point strictly ahead of the counter
  assign lead  = cmp_q - count_in;
  assign ahead = (lead != '0) & ~lead[W-1];

  assign load_cmp = cmp_wr & (~per_en | val_set);
  assign rate_upd = per_clr | (cmp_wr & per_en);

  always_comb begin
    rate_n = rate_q;
    if (per_clr)
      rate_n = '0;
    else if (cmp_wr && per_en)
      rate_n = wdata;
  end

  always_comb begin
    cmp_n  = cmp_q;
    busy_n = busy_q;
    if (load_cmp) begin
      cmp_n  = wdata;
      busy_n = 1'b0;
    end else if (hit && per_en && (rate_q != '0)) begin
      cmp_n  = cmp_q + rate_q;
      busy_n = 1'b1;
    end else if (busy_q) begin
      if (ahead || !per_en || (rate_q == '0))
        busy_n = 1'b0;
      else
        cmp_n = cmp_q + rate_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      rate_q <= '0;
      prev_q <= '0;
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_n;
      busy_q <= busy_n;
      prev_q <= count_in;
      en_q   <= count_en;
      fire_q <= hit;
      if (rate_upd)
        rate_q <= rate_n;
    end
  end

  assign cmp_val = cmp_q;
  assign fire    = fire_q;

  // R2
  fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q);
  // R10
  fire_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> !fire_q);
  // R4
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && per_en && !val_set && !hit && !busy_q) |=> $stable(cmp_q));
  // R7
  rate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !per_en |-> (rate_q == '0));
  // R11
  collide_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && hit) |=> fire_q);
endmodule

// File: rtl/tcb_rdmux.sv
module tcb_rdmux #(
  parameter int unsigned W     = 32,
  parameter int unsigned NT    = 3,
  parameter int unsigned IDX_W = 2
) (
  input  logic [NT*W-1:0] cfg_flat,
  input  logic [NT*W-1:0] cmp_flat,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic            rd_reg,
  output logic [W-1:0]    rd_data
);
  import tcb_pkg::*;

  always_comb begin
    rd_data = '0;
    for (int t = 0; t < NT; t++) begin
      if (rd_idx == IDX_W'(t))
        rd_data = (reg_sel_e'(rd_reg) == REG_CMP) ? cmp_flat[t*W +: W]
                                                  : cfg_flat[t*W +: W];
    end
  end
endmodule

// File: rtl/cmp_timer_bank.sv
module cmp_timer_bank #(
  parameter int unsigned NUM_TMR = 3,
  parameter int unsigned CNT_W   = 32,
  localparam int unsigned IDX_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   count_in,
  input  logic               count_en,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_reg,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic               rd_reg,
  output logic [CNT_W-1:0]   rd_data,
  output logic [NUM_TMR-1:0] fire
);
  import tcb_pkg::*;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync <= 2'b00;
    else
      rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [NUM_TMR*CNT_W-1:0] cfg_flat;
  logic [NUM_TMR*CNT_W-1:0] cmp_flat;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(t);
    logic sel, cfg_wr, cmp_wr;
    logic per_en, val_set, per_clr;

    assign sel    = wr_en & (wr_idx == MY_IDX);
    assign cfg_wr = sel & (reg_sel_e'(wr_reg) == REG_CFG);
    assign cmp_wr = sel & (reg_sel_e'(wr_reg) == REG_CMP);

    tcb_cfg #(.W(CNT_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .cfg_wr  (cfg_wr),
      .cmp_wr  (cmp_wr),
      .per_d   (wr_data[CFG_PER_BIT]),
      .vset_d  (wr_data[CFG_VSET_BIT]),
      .per_en  (per_en),
      .val_set (val_set),
      .per_clr (per_clr),
      .cfg_rd  (cfg_flat[t*CNT_W +: CNT_W])
    );

    tcb_slot #(.W(CNT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .count_in (count_in),
      .count_en (count_en),
      .cmp_wr   (cmp_wr),
      .wdata    (wr_data),
      .per_en   (per_en),
      .val_set  (val_set),
      .per_clr  (per_clr),
      .cmp_val  (cmp_flat[t*CNT_W +: CNT_W]),
      .fire     (fire[t])
    );
  end

  tcb_rdmux #(.W(CNT_W), .NT(NUM_TMR), .IDX_W(IDX_W)) u_rdmux (
    .cfg_flat (cfg_flat),
    .cmp_flat (cmp_flat),
    .rd_idx   (rd_idx),
    .rd_reg   (rd_reg),
    .rd_data  (rd_data)
  );

  // R1
  reset_fire_chk: assert property (@(posedge clk)
    !rst_int_n |=> (fire == '0));
endmodule

// File: tb/cmp_timer_bank_bench.sv
module cmp_timer_bank_bench;
  localparam int NT = 3;
  localparam logic [3:0] OP_EN  = 4'd0;
  localparam logic [3:0] OP_CFG = 4'd1;
  localparam logic [3:0] OP_CMP = 4'd2;
  localparam logic [3:0] OP_CNT = 4'd3;
  localparam logic [3:0] OP_RDC = 4'd4;
  localparam logic [3:0] OP_RDF = 4'd5;
  localparam int NV = 55;

  // {op, timer, data, expected}
  localparam logic [71:0] VEC [NV] = '{
    {OP_RDC, 4'd0, 32'h0,        32'hFFFFFFFF}, // R1
    {OP_RDF, 4'd0, 32'h0,        32'h2},        // R1 R8
    {OP_EN,  4'd0, 32'h1,        32'h0},
    {OP_CNT, 4'd0, 32'h10,       32'h0},
    {OP_CMP, 4'd0, 32'h20,       32'h0},        // R2
    {OP_RDC, 4'd0, 32'h0,        32'h20},       // R9
    {OP_CNT, 4'd0, 32'h1F,       32'h0},
    {OP_CNT, 4'd0, 32'h20,       32'h1},        // R2
    {OP_CNT, 4'd0, 32'h21,       32'h0},        // R2
    {OP_CNT, 4'd0, 32'h30,       32'h0},
    {OP_CMP, 4'd0, 32'h25,       32'h0},        // R3
    {OP_CNT, 4'd0, 32'h40,       32'h0},        // R3
    {OP_CNT, 4'd0, 32'hFFFFFFF0, 32'h0},        // R3
    {OP_CNT, 4'd0, 32'h30,       32'h7},        // R3 wrap
    {OP_CFG, 4'd1, 32'h5,        32'h0},
    {OP_RDF, 4'd1, 32'h0,        32'h7},        // R8
    {OP_CMP, 4'd1, 32'h100,      32'h0},        // R4
    {OP_RDF, 4'd1, 32'h0,        32'h3},        // R5
    {OP_RDC, 4'd1, 32'h0,        32'h100},      // R4
    {OP_CNT, 4'd0, 32'h100,      32'h2},
    {OP_CNT, 4'd0, 32'h100,      32'h0},
    {OP_RDC, 4'd1, 32'h0,        32'h200},      // R6
    {OP_CNT, 4'd0, 32'h200,      32'h2},
    {OP_CNT, 4'd0, 32'h200,      32'h0},
    {OP_RDC, 4'd1, 32'h0,        32'h300},      // R6
    {OP_CNT, 4'd0, 32'h650,      32'h2},        // R6 multi-period
    {OP_CNT, 4'd0, 32'h650,      32'h0},
    {OP_CNT, 4'd0, 32'h650,      32'h0},
    {OP_CNT, 4'd0, 32'h650,      32'h0},
    {OP_CNT, 4'd0, 32'h650,      32'h0},
    {OP_RDC, 4'd1, 32'h0,        32'h700},      // R6
    {OP_CMP, 4'd1, 32'h50,       32'h0},        // R4
    {OP_RDC, 4'd1, 32'h0,        32'h700},      // R4 R9
    {OP_CNT, 4'd0, 32'h700,      32'h2},
    {OP_CNT, 4'd0, 32'h700,      32'h0},
    {OP_RDC, 4'd1, 32'h0,        32'h750},      // R4 new period
    {OP_CFG, 4'd1, 32'h0,        32'h0},        // R7
    {OP_CFG, 4'd1, 32'h1,        32'h0},
    {OP_RDF, 4'd1, 32'h0,        32'h3},
    {OP_CNT, 4'd0, 32'h750,      32'h2},
    {OP_CNT, 4'd0, 32'h750,      32'h0},
    {OP_CNT, 4'd0, 32'h750,      32'h0},
    {OP_RDC, 4'd1, 32'h0,        32'h750},      // R7
    {OP_CFG, 4'd2, 32'hA,        32'h0},        // R8
    {OP_RDF, 4'd2, 32'h0,        32'h2},        // R8
    {OP_CFG, 4'd2, 32'hFFFFFFFF, 32'h0},
    {OP_RDF, 4'd2, 32'h0,        32'h7},        // R8
    {OP_CFG, 4'd2, 32'h0,        32'h0},
    {OP_RDF, 4'd2, 32'h0,        32'h2},
    {OP_EN,  4'd0, 32'h0,        32'h0},        // R10
    {OP_CMP, 4'd0, 32'h800,      32'h0},
    {OP_CNT, 4'd0, 32'h800,      32'h0},        // R10
    {OP_EN,  4'd0, 32'h1,        32'h0},
    {OP_CNT, 4'd0, 32'h801,      32'h0},        // R10
    {OP_RDC, 4'd0, 32'h0,        32'h800}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [31:0]   count_in;
  logic          count_en;
  logic          wr_en;
  logic [1:0]    wr_idx;
  logic          wr_reg;
  logic [31:0]   wr_data;
  logic [1:0]    rd_idx;
  logic          rd_reg;
  logic [31:0]   rd_data;
  logic [NT-1:0] fire;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  cmp_timer_bank u_cmp_timer_bank (
    .clk(clk), .rst_n(rst_n), .count_in(count_in), .count_en(count_en),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_reg(wr_reg), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_reg(rd_reg), .rd_data(rd_data), .fire(fire)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_wr(input logic [1:0] idx, input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_reg = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] idx, input logic sel,
                        input logic [31:0] exp);
    rd_idx = idx; rd_reg = sel;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; count_in = '0; count_en = 1'b0;
    wr_en = 1'b0; wr_idx = '0; wr_reg = 1'b0; wr_data = '0;
    rd_idx = '0; rd_reg = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state while held
    check("R1 fire in reset", 32'(fire), 32'h0);
    for (int t = 0; t < NT; t++) rd_chk("R1 cmp in reset", 2'(t), 1'b1, 32'hFFFFFFFF);
    rst_n = 1'b1;
    repeat (4) tick();

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  op;
      logic [1:0]  idx;
      logic [31:0] d, e;
      op = VEC[i][71:68]; idx = VEC[i][65:64]; d = VEC[i][63:32]; e = VEC[i][31:0];
      case (op)
        OP_EN:  begin count_en = d[0]; tick(); end
        OP_CFG: do_wr(idx, 1'b0, d);
        OP_CMP: do_wr(idx, 1'b1, d);
        OP_CNT: begin
          count_in = d;
          tick();
          check($sformatf("vec %0d fire", i), 32'(fire), e);
        end
        OP_RDC: rd_chk($sformatf("vec %0d comparator", i), idx, 1'b1, e);
        OP_RDF: rd_chk($sformatf("vec %0d config", i), idx, 1'b0, e);
        default: ;
      endcase
    end

    // R11 one-shot: write and match in the same cycle
    do_wr(2'd0, 1'b1, 32'h900);
    count_in = 32'h900;
    do_wr(2'd0, 1'b1, 32'h950);
    check("R11 one-shot collision fire", 32'(fire), 32'h1);
    rd_chk("R11 written value wins", 2'd0, 1'b1, 32'h950);
    tick();
    check("R2 pulse is one cycle", 32'(fire), 32'h0);

    // R11 periodic: period-only write during a match
    do_wr(2'd0, 1'b1, 32'h5000);
    do_wr(2'd1, 1'b0, 32'h5);
    do_wr(2'd1, 1'b1, 32'h1000);
    count_in = 32'h1000;
    do_wr(2'd1, 1'b1, 32'h40);
    check("R11 periodic collision fire", 32'(fire), 32'h2);
    repeat (3) tick();
    rd_chk("R11 step uses old period", 2'd1, 1'b1, 32'h2000);
    count_in = 32'h2000;
    tick();
    check("R6 fire at stepped value", 32'(fire), 32'h2);
    repeat (3) tick();
    rd_chk("R4 new period applies", 2'd1, 1'b1, 32'h2040);

    // R1 reset mid-run
    rst_n = 1'b0;
    #1;
    check("R1 fire after reset", 32'(fire), 32'h0);
    rd_chk("R1 cmp after reset", 2'd1, 1'b1, 32'hFFFFFFFF);
    rd_chk("R1 cfg after reset", 2'd1, 1'b0, 32'h2);
    tick();
    rst_n = 1'b1;
    repeat (3) tick();
    finish_run();
  end
endmodule